// File: doc/BRIEF.md
# Word-Wide DMA Staging FIFO with Transfer Counter

This block is a byte FIFO, 16 entries deep by default, between a byte-wide device data path and a 16-bit DMA port. The device side pushes and pops single bytes. The DMA side moves little-endian words. When the FIFO is nearly full, when the transfer counter is about to expire, or when the FIFO holds only one byte, a word transfer falls back to moving one byte.

A down-counting transfer counter is loaded by the processor and counts the bytes that cross the DMA port. It saturates at zero. The first time it reaches zero, a sticky terminal-count flag is set and the FIFO occupancy at that moment is captured as the residual length. A DMA request line is derived from the selected direction, the occupancy, the terminal-count flag and two configuration bits. One bit keeps the last byte back for the processor. The other marks synchronous transfers.

Top module: `sfd_dma_fifo`

## Requirements
- R1: A word write that is not reduced to a byte (see R2) pushes bits 7:0 first and bits 15:8 second, and lowers the counter by 2.
- R2: A word write is reduced to a single-byte push of bits 7:0 when the FIFO holds more than DEPTH-2 bytes or the counter equals 1. The counter then drops by 1.
- R3: A word write or a device push into a full FIFO changes nothing: the occupancy, the counter and the stored bytes keep their values.
- R4: When the FIFO holds at least 2 bytes, a word read returns the oldest byte on bits 7:0 and the next byte on bits 15:8. It removes both bytes and lowers the counter by 2.
- R5: When the FIFO holds exactly 1 byte, a word read returns that byte on bits 7:0 with 0xFF on bits 15:8. It removes the byte and lowers the counter by 1. On an empty FIFO a word read changes nothing.
- R6: The counter never goes below zero: a decrement larger than its value leaves it at 0.
- R7: The terminal-count flag is set by the first decrement that leaves the counter at zero. The residual length then takes the occupancy after that transfer. While the flag stays set, later transfers change neither the flag nor the residual length.
- R8: A counter load writes the new value and clears the terminal-count flag.
- R9: The DMA request is low when the direction field (`cfg_dir`) is 00 (idle) or 11 (reserved).
- R10: With direction 01 (device to memory), the request is high when the occupancy exceeds 1 if `cfg_keep_resid` is set, or exceeds 0 if it is clear. When `cfg_sync` is set, the terminal-count flag must also be clear.
- R11: With direction 10 (memory to device), the request is high when the FIFO is not full and the terminal-count flag is clear.
- R12: After reset the FIFO is empty, the counter is 0, the residual length is 0 and the terminal-count flag is clear.
- R13: Device-side bytes leave in the order they entered, and a device pop on an empty FIFO changes nothing. At most one of the strobes (device push, device pop, word write, word read, counter load) is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dir | input | 2 | DMA direction: 00 idle, 01 device to memory, 10 memory to device, 11 reserved |
| cfg_keep_resid | input | 1 | Hold the last byte back from the DMA in the device-to-memory direction |
| cfg_sync | input | 1 | Synchronous mode: terminal count blocks the device-to-memory request |
| cnt_load | input | 1 | Load strobe for the transfer counter |
| cnt_value | input | CNT_W | Value loaded into the counter |
| dev_push | input | 1 | Device-side byte push strobe |
| dev_wdata | input | 8 | Device-side byte to push |
| dev_pop | input | 1 | Device-side byte pop strobe |
| dev_rdata | output | 8 | Oldest FIFO byte |
| dma_wr | input | 1 | DMA word write strobe |
| dma_wdata | input | 16 | DMA write word |
| dma_rd | input | 1 | DMA word read strobe |
| dma_rdata | output | 16 | DMA read word, valid in the cycle of the read strobe |
| dma_req | output | 1 | DMA request |
| tc_flag | output | 1 | Terminal-count flag |
| resid_len | output | OCC_W | Occupancy captured when the counter first reached zero |
| fifo_level | output | OCC_W | Bytes held in the FIFO |
| xfer_count | output | CNT_W | Transfer counter value |

## Verification
The assertions assume that the strobes are mutually exclusive. Each cycle carries at most one push, pop, word transfer or counter load. The FIFO storage therefore never has to merge a device access with a DMA access. The stimulus picks exactly one operation per cycle, or none, and drives it half a clock before the edge. Configuration changes happen only between operations. The generator keeps operating on full and empty FIFOs, because the assertions must hold for those ignored accesses too.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
   typedef enum logic [1:0] {
      DIR_IDLE     = 2'b00,
      DIR_TO_MEM   = 2'b01,
      DIR_FROM_MEM = 2'b10,
      DIR_RSVD     = 2'b11
   } dma_dir_e;

   // number of bytes moved in one cycle
   typedef logic [1:0] nbytes_t;
endpackage

// File: rtl/sfd_byte_fifo.sv
module sfd_byte_fifo #(
   parameter int DEPTH = 16,
   parameter int OCC_W = $clog2(DEPTH + 1),
   parameter int PTR_W = $clog2(DEPTH)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  sfd_pkg::nbytes_t    push_n,
   input  logic [7:0]          push_lo,
   input  logic [7:0]          push_hi,
   input  sfd_pkg::nbytes_t    pop_n,
   output logic [7:0]          head0,
   output logic [7:0]          head1,
   output logic [OCC_W-1:0]    level
);
   localparam logic [OCC_W-1:0] LVL_FULL = OCC_W'(DEPTH);

   logic [7:0]       mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [PTR_W-1:0] wr_ptr_nx1, rd_ptr_nx1;

   assign wr_ptr_nx1 = wr_ptr + PTR_W'(1);
   assign rd_ptr_nx1 = rd_ptr + PTR_W'(1);

   // each entry takes the low byte at the write pointer and the high
   // byte one slot further when two bytes arrive together
   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      logic take_lo, take_hi;
      assign take_lo = (push_n != 2'd0) && (wr_ptr == PTR_W'(e));
      assign take_hi = (push_n == 2'd2) && (wr_ptr_nx1 == PTR_W'(e));
      always_ff @(posedge clk) begin
         if (take_lo)      mem[e] <= push_lo;
         else if (take_hi) mem[e] <= push_hi;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         wr_ptr <= wr_ptr + PTR_W'(push_n);
         rd_ptr <= rd_ptr + PTR_W'(pop_n);
         level  <= level + OCC_W'(push_n) - OCC_W'(pop_n);
      end
   end

   assign head0 = mem[rd_ptr];
   assign head1 = mem[rd_ptr_nx1];

   AST_LVL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_FULL); // R13
   AST_PUSH_FITS: assert property (@(posedge clk) disable iff (!rst_n)
      push_n != 2'd0 |-> (level + OCC_W'(push_n)) <= LVL_FULL); // R3
   AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      pop_n != 2'd0 |-> level >= OCC_W'(pop_n)); // R5
   AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (level == LVL_FULL && pop_n == 2'd0) |=> level == LVL_FULL); // R3
endmodule

// File: rtl/sfd_xfer_count.sv
module sfd_xfer_count #(
   parameter int CNT_W = 16,
   parameter int OCC_W = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [CNT_W-1:0]    load_val,
   input  sfd_pkg::nbytes_t    dec_n,
   input  logic [OCC_W-1:0]    level_after,
   output logic [CNT_W-1:0]    count,
   output logic                tc,
   output logic [OCC_W-1:0]    resid
);
   logic [CNT_W-1:0] dec_w, cnt_next;
   logic             hit_zero;

   assign dec_w    = CNT_W'(dec_n);
   assign cnt_next = (count > dec_w) ? count - dec_w : '0;
   assign hit_zero = (dec_n != 2'd0) && (cnt_next == '0) && !tc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
         tc    <= 1'b0;
         resid <= '0;
      end else if (load) begin
         count <= load_val;
         tc    <= 1'b0;
      end else if (dec_n != 2'd0) begin
         count <= cnt_next;
         if (hit_zero) begin
            tc    <= 1'b1;
            resid <= level_after;
         end
      end
   end

   AST_TC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (tc && !load) |=> tc); // R7
   AST_RESID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (tc && !load) |=> $stable(resid)); // R7
   AST_TC_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tc) |-> count == '0); // R6
   AST_CNT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> count <= $past(count)); // R6
   AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (!tc && count == $past(load_val))); // R8
endmodule

// File: rtl/sfd_req_gen.sv
module sfd_req_gen #(
   parameter int DEPTH = 16,
   parameter int OCC_W = $clog2(DEPTH + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  sfd_pkg::dma_dir_e   dir,
   input  logic                keep_resid,
   input  logic                sync_mode,
   input  logic [OCC_W-1:0]    level,
   input  logic                tc,
   output logic                req
);
   import sfd_pkg::*;
   localparam logic [OCC_W-1:0] LVL_FULL = OCC_W'(DEPTH);

   logic [OCC_W-1:0] in_floor;
   assign in_floor = keep_resid ? OCC_W'(1) : OCC_W'(0);

   always_comb begin
      unique case (dir)
         DIR_TO_MEM:   req = (level > in_floor) && !(sync_mode && tc);
         DIR_FROM_MEM: req = (level != LVL_FULL) && !tc;
         default:      req = 1'b0;
      endcase
   end

   AST_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (dir == DIR_IDLE || dir == DIR_RSVD) |-> !req); // R9
   AST_REQ_SYNC_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (dir == DIR_TO_MEM && sync_mode && tc) |-> !req); // R10
   AST_REQ_OUT_TC: assert property (@(posedge clk) disable iff (!rst_n)
      (dir == DIR_FROM_MEM && tc) |-> !req); // R11
endmodule

// File: rtl/sfd_dma_fifo.sv
module sfd_dma_fifo #(
   parameter int DEPTH = 16,
   parameter int CNT_W = 16,
   parameter int OCC_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_dir,
   input  logic              cfg_keep_resid,
   input  logic              cfg_sync,
   input  logic              cnt_load,
   input  logic [CNT_W-1:0]  cnt_value,
   input  logic              dev_push,
   input  logic [7:0]        dev_wdata,
   input  logic              dev_pop,
   output logic [7:0]        dev_rdata,
   input  logic              dma_wr,
   input  logic [15:0]       dma_wdata,
   input  logic              dma_rd,
   output logic [15:0]       dma_rdata,
   output logic              dma_req,
   output logic              tc_flag,
   output logic [OCC_W-1:0]  resid_len,
   output logic [OCC_W-1:0]  fifo_level,
   output logic [CNT_W-1:0]  xfer_count
);
   import sfd_pkg::*;

   localparam int PTR_W = $clog2(DEPTH);
   localparam logic [OCC_W-1:0] LVL_FULL     = OCC_W'(DEPTH);
   localparam logic [OCC_W-1:0] LVL_WORD_MAX = OCC_W'(DEPTH - 2);

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("sfd_dma_fifo: DEPTH must be a power of two of at least 4");
   end
   if (OCC_W < $clog2(DEPTH + 1)) begin : g_bad_occ
      $error("sfd_dma_fifo: OCC_W too narrow for DEPTH");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("sfd_dma_fifo: CNT_W must be at least 2");
   end

   logic [OCC_W-1:0] lvl, lvl_after;
   logic [7:0]       head0, head1;
   logic             wr_word, wr_byte, rd_word, rd_byte, dv_push, dv_pop;
   nbytes_t          push_n, pop_n, dec_n;

   // word write shrinks to a byte near the top of the FIFO or at count 1
   assign wr_word = dma_wr && (lvl <= LVL_WORD_MAX) && (xfer_count != CNT_W'(1));
   assign wr_byte = dma_wr && !wr_word && (lvl != LVL_FULL);
   assign rd_word = dma_rd && (lvl >= OCC_W'(2));
   assign rd_byte = dma_rd && (lvl == OCC_W'(1));
   assign dv_push = dev_push && (lvl != LVL_FULL);
   assign dv_pop  = dev_pop && (lvl != '0);

   assign push_n = wr_word ? 2'd2 : ((wr_byte || dv_push) ? 2'd1 : 2'd0);
   assign pop_n  = rd_word ? 2'd2 : ((rd_byte || dv_pop)  ? 2'd1 : 2'd0);
   assign dec_n  = (wr_word || rd_word) ? 2'd2 : ((wr_byte || rd_byte) ? 2'd1 : 2'd0);
   assign lvl_after = lvl + OCC_W'(push_n) - OCC_W'(pop_n);

   sfd_byte_fifo #(.DEPTH(DEPTH), .OCC_W(OCC_W), .PTR_W(PTR_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_n  (push_n),
      .push_lo (dma_wr ? dma_wdata[7:0] : dev_wdata),
      .push_hi (dma_wdata[15:8]),
      .pop_n   (pop_n),
      .head0   (head0),
      .head1   (head1),
      .level   (lvl)
   );

   sfd_xfer_count #(.CNT_W(CNT_W), .OCC_W(OCC_W)) u_count (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (cnt_load),
      .load_val    (cnt_value),
      .dec_n       (dec_n),
      .level_after (lvl_after),
      .count       (xfer_count),
      .tc          (tc_flag),
      .resid       (resid_len)
   );

   sfd_req_gen #(.DEPTH(DEPTH), .OCC_W(OCC_W)) u_req (
      .clk        (clk),
      .rst_n      (rst_n),
      .dir        (dma_dir_e'(cfg_dir)),
      .keep_resid (cfg_keep_resid),
      .sync_mode  (cfg_sync),
      .level      (lvl),
      .tc         (tc_flag),
      .req        (dma_req)
   );

   assign fifo_level = lvl;
   assign dev_rdata  = head0;
   assign dma_rdata  = {(lvl >= OCC_W'(2)) ? head1 : 8'hFF, head0};

   AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dev_push, dev_pop, dma_wr, dma_rd, cnt_load})); // R13
   AST_WR_AT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_wr && xfer_count == CNT_W'(1) && lvl != LVL_FULL)
      |=> (fifo_level == $past(lvl) + OCC_W'(1) && xfer_count == '0)); // R2
   AST_FULL_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      ((dma_wr || dev_push) && lvl == LVL_FULL)
      |=> (fifo_level == LVL_FULL && xfer_count == $past(xfer_count))); // R3
   AST_RD_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_rd && lvl == OCC_W'(1)) |=> fifo_level == '0); // R5
endmodule

// File: tb/test_sfd_dma_fifo.sv
`timescale 1ns/1ps
module test_sfd_dma_fifo;
   localparam int D = 16;
   localparam int CW = 16;
   localparam int OW = 5;

   logic clk = 0, rst_n = 0;
   logic [1:0] cfg_dir = 0;
   logic cfg_keep_resid = 0, cfg_sync = 0, cnt_load = 0;
   logic [CW-1:0] cnt_value = 0;
   logic dev_push = 0, dev_pop = 0, dma_wr = 0, dma_rd = 0;
   logic [7:0] dev_wdata = 0;
   logic [15:0] dma_wdata = 0;
   logic [7:0] dev_rdata;
   logic [15:0] dma_rdata;
   logic dma_req, tc_flag;
   logic [OW-1:0] resid_len, fifo_level;
   logic [CW-1:0] xfer_count;

   sfd_dma_fifo #(.DEPTH(D), .CNT_W(CW)) i_sfd_dma_fifo (.*);

   always #2.5 clk = ~clk;

   int total = 0, bad = 0;
   bit done = 0;

   // reference model
   logic [7:0] q [0:D-1];
   int n = 0, m_cnt = 0, m_resid = 0;
   bit m_tc = 0;

   task automatic chk(string rq, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
      end
   endtask

   function automatic bit exp_req();
      case (cfg_dir)
         2'b01: return (n > (cfg_keep_resid ? 1 : 0)) && !(cfg_sync && m_tc);
         2'b10: return (n < D) && !m_tc;
         default: return 0;
      endcase
   endfunction

   task automatic m_push(logic [7:0] b); q[n] = b; n++; endtask
   task automatic m_pop(int k);
      for (int i = 0; i < D - k; i++) q[i] = q[i + k];
      n -= k;
   endtask
   task automatic m_dec(int k);
      int nx;
      if (k == 0) return;
      nx = (m_cnt > k) ? m_cnt - k : 0;
      if (nx == 0 && !m_tc) begin m_tc = 1; m_resid = n; end
      m_cnt = nx;
   endtask

   task automatic compare(string tag);
      chk({tag, " R13 level"}, fifo_level, n);
      chk({tag, " R6 count"}, xfer_count, m_cnt);
      chk({tag, " R7 tc"}, tc_flag, m_tc);
      chk({tag, " R7 resid"}, resid_len, m_resid);
      chk({tag, " R10 R11 req"}, dma_req, exp_req());
   endtask

   // op: 0 idle,1 dev push,2 dev pop,3 word write,4 word read,5 load
   task automatic step(int op, int val, string tag);
      int k;
      @(negedge clk);
      case (op)
         1: begin dev_push = 1; dev_wdata = val[7:0]; end
         2: dev_pop = 1;
         3: begin dma_wr = 1; dma_wdata = val[15:0]; end
         4: dma_rd = 1;
         5: begin cnt_load = 1; cnt_value = val[CW-1:0]; end
         default: ;
      endcase
      #1;
      if (op == 2 && n > 0) chk({tag, " R13 dev data"}, dev_rdata, q[0]);
      if (op == 4 && n >= 2) chk({tag, " R4 word"}, dma_rdata, {q[1], q[0]});
      if (op == 4 && n == 1) chk({tag, " R5 short word"}, dma_rdata, {8'hFF, q[0]});
      @(posedge clk); #1;
      dev_push = 0; dev_pop = 0; dma_wr = 0; dma_rd = 0; cnt_load = 0;
      case (op)
         1: if (n < D) m_push(val[7:0]);
         2: if (n > 0) m_pop(1);
         3: begin
            if (n <= D - 2 && m_cnt != 1) begin
               m_push(val[7:0]); m_push(val[15:8]); k = 2;
            end else if (n < D) begin m_push(val[7:0]); k = 1; end
            else k = 0;
            m_dec(k);
         end
         4: begin
            k = (n >= 2) ? 2 : n;
            m_pop(k); m_dec(k);
         end
         5: begin m_cnt = val & 16'hFFFF; m_tc = 0; end
         default: ;
      endcase
      compare(tag);
   endtask

   task automatic drain(string tag);
      while (n > 0) step(2, 0, tag);
   endtask

   initial begin
      #(5.0 * 190000);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int s, op, v;
      s = $urandom(32'h5A17);
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      #1;
      // R12 reset state
      chk("R12 level", fifo_level, 0);
      chk("R12 count", xfer_count, 0);
      chk("R12 tc", tc_flag, 0);
      chk("R12 resid", resid_len, 0);

      // R1 little-endian word write, R4 word read
      step(5, 100, "R8 load");
      step(3, 16'hB2A1, "R1 write");
      chk("R1 order", dev_rdata, 8'hA1);
      step(3, 16'hD4C3, "R1 write2");
      step(4, 0, "R4 read");
      step(2, 0, "R1 hi byte pop");
      step(2, 0, "R1 second lo");
      drain("drain");
      // R2 fallback at level above D-2
      for (int i = 0; i < D - 1; i++) step(1, i + 8'h30, "R13 fill");
      step(3, 16'hEE77, "R2 write at 15");
      chk("R2 full", fifo_level, D);
      // R3 ignored writes at full
      step(3, 16'h1111, "R3 word at full");
      step(1, 8'h22, "R3 push at full");
      for (int i = 0; i < D - 1; i++) step(2, 0, "R3 contents");
      chk("R2 low byte kept", dev_rdata, 8'h77);
      step(2, 0, "R2 last");
      step(2, 0, "R13 pop empty");
      step(4, 0, "R5 read empty");
      // R2 counter equals 1
      step(5, 1, "R8 load one");
      step(3, 16'h9988, "R2 cnt one");
      chk("R2 one byte", fifo_level, 1);
      chk("R7 tc set", tc_flag, 1);
      step(3, 16'h4455, "R7 after tc");
      // R5 single-byte word read
      drain("drain2");
      step(1, 8'h5C, "R5 setup");
      step(4, 0, "R5 short");
      // R6 saturation
      step(5, 1, "R8 load one b");
      step(1, 8'h01, "R6 setup"); step(1, 8'h02, "R6 setup");
      step(4, 0, "R6 saturate");
      chk("R6 zero", xfer_count, 0);
      // R9..R11 request modes
      for (int dsel = 0; dsel < 4; dsel++)
         for (int kr = 0; kr < 2; kr++)
            for (int sy = 0; sy < 2; sy++) begin
               @(negedge clk);
               cfg_dir = dsel[1:0]; cfg_keep_resid = kr[0]; cfg_sync = sy[0];
               step(1, dsel * 4 + kr, "R9 R10 req mode");
               step(0, 0, "R9 R10 idle");
            end
      drain("drain3");

      // constrained random
      for (int it = 0; it < 4000; it++) begin
         if (it % 97 == 0) begin
            @(negedge clk);
            cfg_dir = 2'($urandom_range(0, 3));
            cfg_keep_resid = 1'($urandom_range(0, 1));
            cfg_sync = 1'($urandom_range(0, 1));
         end
         v = $urandom;
         op = $urandom_range(0, 19);
         if (op < 5) step(1, v, "rand push");
         else if (op < 9) step(2, 0, "rand pop");
         else if (op < 13) step(3, v, "rand wr");
         else if (op < 17) step(4, 0, "rand rd");
         else if (op < 18) step(5, v % 24, "rand load");
         else step(0, 0, "rand idle");
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule